// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Port for a Display Controller

This block is the host-facing front end of a display controller. A host processor drives it with either a strobe-per-direction bus (separate active-low read and write strobes, 8080 style) or an enable-qualified bus (one enable plus a read/not-write line, 6800 style). A static mode input picks the style. In both styles a register-select line splits each cycle into one of two paths. With select low the cycle either reads a status word or loads an 8-bit index. With select high it either reads display memory or writes data.

Written data is latched into a write holding register. On the next clock it moves without any host involvement to one of three places, chosen by the index: the display memory port, an internal memory pointer, or the external control register bus. Memory reads go through a read holding register that runs one word ahead of the host. The first read after an index load returns a dummy word, and each completed read prefetches the next word at an auto-incremented address. All bus inputs pass through a two-flop synchroniser. Actions fire on the trailing edge of the active strobe, so the host never sees a busy wait.

Top module: `hbif_top`

## Requirements
- R1: With `mode_6800`=0, a low pulse on `bus_wr_n` with `bus_rs`=0 loads `bus_din` into the index register, and a low pulse on `bus_rd_n` performs a read. `bus_rs`=1 selects the data path instead.
- R2: With `mode_6800`=1, a cycle is qualified by `bus_en`=1. `bus_rnw`=0 is a write that takes effect when `bus_en` falls, and `bus_rnw`=1 is a read. `bus_rs` selects the path exactly as in R1.
- R3: A status read (`bus_rs`=0) returns bit 7 = 0 (never busy), bits 6:0 = index bits 6:0, and zero in any bit above 7.
- R4: A data write while the index is neither 0x20 nor 0x22 gives exactly one `ctrl_we` pulse, with `ctrl_addr` equal to the index and `ctrl_wdata` equal to the written data. No memory write occurs.
- R5: A data write while the index is 0x20 loads the memory pointer with the written value and produces no `ram_we` and no `ctrl_we`.
- R6: A data write while the index is 0x22 produces one `ram_we` pulse at the current pointer with the written data, and the pointer then increments by one.
- R7: Loading the index clears the read holding register. The first data read with index 0x22 therefore returns 0x00. Each such read then fetches the word at the pointer and increments the pointer, so the following reads return consecutive memory words.
- R8: Data writes spaced by 3-cycle strobe pulses and 3-cycle gaps are all accepted and transferred, with no busy indication.
- R9: After reset, `bus_dout` is 0 and `ctrl_we`, `ram_we` and `ram_re` are 0.
- R10: The strobes of the unselected style are ignored: `bus_en` in 8080 mode, and `bus_rd_n`/`bus_wr_n` in 6800 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_6800 | input | 1 | Static bus style: 0 = separate read/write strobes, 1 = enable with read/not-write |
| bus_rs | input | 1 | Register select: 0 = index/status path, 1 = data path |
| bus_rd_n | input | 1 | Active-low read strobe (8080 style) |
| bus_wr_n | input | 1 | Active-low write strobe (8080 style) |
| bus_rnw | input | 1 | Read (1) / write (0) direction (6800 style) |
| bus_en | input | 1 | Active-high cycle enable (6800 style) |
| bus_din | input | DW | Host write data |
| bus_dout | output | DW | Host read data (status or read holding register) |
| ctrl_we | output | 1 | One-cycle control register write strobe |
| ctrl_addr | output | 8 | Control register index |
| ctrl_wdata | output | DW | Control register write data |
| ram_we | output | 1 | Display memory write strobe |
| ram_re | output | 1 | Display memory read strobe (data returns next cycle) |
| ram_addr | output | AW | Display memory address |
| ram_wdata | output | DW | Display memory write data |
| ram_rdata | input | DW | Display memory read data, one cycle after `ram_re` |

## Verification
The hardest situation to reach from the ports is a read holding register that is one word ahead of the host. The value on `bus_dout` during a read was fetched by the previous read, and the value fetched now stays hidden until the next read. To check this, the stimulus first fills memory through the pointer and data-port indexes. It then reloads the index, which forces the dummy word, and reads back a run of words in both bus styles. A tight burst of short write pulses checks that back-to-back writes are not lost at the synchroniser.

// File: rtl/hbif_pkg.sv
package hbif_pkg;

    localparam int IDX_W = 8;

    typedef enum logic [2:0] {
        HB_NONE    = 3'd0,
        HB_STAT_RD = 3'd1,
        HB_IDX_WR  = 3'd2,
        HB_DAT_RD  = 3'd3,
        HB_DAT_WR  = 3'd4
    } hb_op_e;

endpackage

// File: rtl/hbif_sync.sv
module hbif_sync #(
    parameter int          W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sy_t;

    sy_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST;
            st_q.s2 <= RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/hbif_decode.sv
module hbif_decode
    import hbif_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mode_6800,
    input  logic   rs,
    input  logic   rd_n,
    input  logic   wr_n,
    input  logic   rnw,
    input  logic   en,
    output hb_op_e op
);
    typedef struct packed {
        logic rd_act;
        logic wr_act;
    } dec_t;

    dec_t st_d, st_q;
    logic rd_now, wr_now;

    always_comb begin
        if (mode_6800) begin
            rd_now = en & rnw;
            wr_now = en & ~rnw;
        end else begin
            rd_now = ~rd_n;
            wr_now = ~wr_n;
        end
        st_d.rd_act = rd_now;
        st_d.wr_act = wr_now;
        op = HB_NONE;
        if (st_q.wr_act && !wr_now) begin
            op = rs ? HB_DAT_WR : HB_IDX_WR;
        end else if (st_q.rd_act && !rd_now) begin
            op = rs ? HB_DAT_RD : HB_STAT_RD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_OP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (op != HB_NONE) |-> $past(rd_now || wr_now)); // R1
endmodule

// File: rtl/hbif_core.sv
module hbif_core
    import hbif_pkg::*;
#(
    parameter int            DW      = 8,
    parameter int            AW      = 8,
    parameter logic [IDX_W-1:0] PTR_IDX = 8'h20,
    parameter logic [IDX_W-1:0] RAM_IDX = 8'h22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hb_op_e           op,
    input  logic             rs_s,
    input  logic [DW-1:0]    din_s,
    output logic             ctrl_we,
    output logic [IDX_W-1:0] ctrl_addr,
    output logic [DW-1:0]    ctrl_wdata,
    output logic             ram_we,
    output logic             ram_re,
    output logic [AW-1:0]    ram_addr,
    output logic [DW-1:0]    ram_wdata,
    input  logic [DW-1:0]    ram_rdata,
    output logic [DW-1:0]    dout
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    wdr;
        logic [DW-1:0]    rdr;
        logic [AW-1:0]    ptr;
        logic             wr_pend;
        logic             rd_pend;
        logic             fill;
        logic [DW-1:0]    dout;
    } core_t;

    core_t st_d, st_q;
    logic [DW-1:0] status;

    always_comb begin
        st_d         = st_q;
        st_d.wr_pend = 1'b0;
        st_d.rd_pend = 1'b0;
        ctrl_we      = 1'b0;
        ram_we       = 1'b0;
        ram_re       = 1'b0;

        status       = '0;
        status[6:0]  = st_q.idx[6:0];

        // automatic transfer of the write holding register
        if (st_q.wr_pend) begin
            if (st_q.idx == RAM_IDX) begin
                ram_we   = 1'b1;
                st_d.ptr = st_q.ptr + 1'b1;
            end else if (st_q.idx == PTR_IDX) begin
                st_d.ptr = AW'(st_q.wdr);
            end else begin
                ctrl_we  = 1'b1;
            end
        end

        // prefetch issue for the read holding register
        if (st_q.rd_pend) begin
            ram_re   = 1'b1;
            st_d.ptr = st_q.ptr + 1'b1;
        end
        st_d.fill = ram_re;
        if (st_q.fill) begin
            st_d.rdr = ram_rdata;
        end

        unique case (op)
            HB_IDX_WR: begin
                st_d.idx = din_s;
                st_d.rdr = '0;
            end
            HB_DAT_WR: begin
                st_d.wdr     = din_s;
                st_d.wr_pend = 1'b1;
            end
            HB_DAT_RD: begin
                if (st_q.idx == RAM_IDX) begin
                    st_d.rd_pend = 1'b1;
                end
            end
            default: ;
        endcase

        st_d.dout = rs_s ? st_q.rdr : status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_addr  = st_q.idx;
    assign ctrl_wdata = st_q.wdr;
    assign ram_addr   = st_q.ptr;
    assign ram_wdata  = st_q.wdr;
    assign dout       = st_q.dout;

    AST_XFER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re)); // R6
    AST_CTRL_NOT_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_we && ram_we)); // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |=> (ram_addr == $past(ram_addr) + 1'b1)); // R6
    AST_FILL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> st_q.fill); // R7
    AST_DUMMY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op == HB_IDX_WR) |=> (st_q.rdr == '0)); // R7
    AST_WPEND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_pend |=> !st_q.wr_pend); // R8
endmodule

// File: rtl/hbif_top.sv
module hbif_top
    import hbif_pkg::*;
#(
    parameter int               DW      = 8,
    parameter int               AW      = 8,
    parameter logic [IDX_W-1:0] PTR_IDX = 8'h20,
    parameter logic [IDX_W-1:0] RAM_IDX = 8'h22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_6800,
    input  logic             bus_rs,
    input  logic             bus_rd_n,
    input  logic             bus_wr_n,
    input  logic             bus_rnw,
    input  logic             bus_en,
    input  logic [DW-1:0]    bus_din,
    output logic [DW-1:0]    bus_dout,
    output logic             ctrl_we,
    output logic [IDX_W-1:0] ctrl_addr,
    output logic [DW-1:0]    ctrl_wdata,
    output logic             ram_we,
    output logic             ram_re,
    output logic [AW-1:0]    ram_addr,
    output logic [DW-1:0]    ram_wdata,
    input  logic [DW-1:0]    ram_rdata
);
    localparam int           SW      = DW + 5;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, {DW{1'b0}}};

    logic [SW-1:0] raw, syn;
    logic          rs_s, rd_n_s, wr_n_s, rnw_s, en_s;
    logic [DW-1:0] din_s;
    hb_op_e        op;

    assign raw = {bus_rs, bus_rd_n, bus_wr_n, bus_rnw, bus_en, bus_din};
    assign {rs_s, rd_n_s, wr_n_s, rnw_s, en_s, din_s} = syn;

    hbif_sync #(.W(SW), .RST(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    hbif_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_6800 (mode_6800),
        .rs        (rs_s),
        .rd_n      (rd_n_s),
        .wr_n      (wr_n_s),
        .rnw       (rnw_s),
        .en        (en_s),
        .op        (op)
    );

    hbif_core #(.DW(DW), .AW(AW), .PTR_IDX(PTR_IDX), .RAM_IDX(RAM_IDX)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .rs_s       (rs_s),
        .din_s      (din_s),
        .ctrl_we    (ctrl_we),
        .ctrl_addr  (ctrl_addr),
        .ctrl_wdata (ctrl_wdata),
        .ram_we     (ram_we),
        .ram_re     (ram_re),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_rdata  (ram_rdata),
        .dout       (bus_dout)
    );
endmodule

// File: tb/hbif_top_tb.sv
`timescale 1ns/1ps
module hbif_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_6800 = 1'b0;
    logic       bus_rs = 1'b0, bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_rnw = 1'b1, bus_en = 1'b0;
    logic [7:0] bus_din = '0, bus_dout;
    logic       ctrl_we, ram_we, ram_re;
    logic [7:0] ctrl_addr, ctrl_wdata, ram_addr, ram_wdata;
    logic [7:0] ram_rdata = '0;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hbif_top u_dut (
        .clk(clk), .rst_n(rst_n), .mode_6800(mode_6800),
        .bus_rs(bus_rs), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_rnw(bus_rnw), .bus_en(bus_en), .bus_din(bus_din), .bus_dout(bus_dout),
        .ctrl_we(ctrl_we), .ctrl_addr(ctrl_addr), .ctrl_wdata(ctrl_wdata),
        .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // display memory model and observers
    logic [7:0] mem [256];
    int ctrl_cnt = 0, ram_wr_cnt = 0;
    logic [7:0] last_caddr = '0, last_cdata = '0;
    always @(posedge clk) begin
        if (ram_we) begin mem[ram_addr] <= ram_wdata; ram_wr_cnt <= ram_wr_cnt + 1; end
        if (ram_re) ram_rdata <= mem[ram_addr];
        if (ctrl_we) begin ctrl_cnt <= ctrl_cnt + 1; last_caddr <= ctrl_addr; last_cdata <= ctrl_wdata; end
    end

    typedef struct packed {
        logic       m68;
        logic       rd;
        logic       rs;
        logic [7:0] val;
        logic [3:0] req;
    } vec_t;
    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 8'h20, 4'd5},  // R5 index -> pointer
        '{1'b0, 1'b0, 1'b1, 8'h10, 4'd5},  // R5 pointer = 0x10
        '{1'b0, 1'b0, 1'b0, 8'h22, 4'd1},  // R1 index -> memory port
        '{1'b0, 1'b0, 1'b1, 8'hA1, 4'd6},  // R6
        '{1'b0, 1'b0, 1'b1, 8'hB2, 4'd6},  // R6
        '{1'b0, 1'b1, 1'b0, 8'h22, 4'd1},  // R1 status shows index
        '{1'b0, 1'b0, 1'b0, 8'h20, 4'd5},
        '{1'b0, 1'b0, 1'b1, 8'h10, 4'd5},
        '{1'b0, 1'b0, 1'b0, 8'h22, 4'd7},
        '{1'b0, 1'b1, 1'b1, 8'h00, 4'd7},  // R7 dummy
        '{1'b0, 1'b1, 1'b1, 8'hA1, 4'd7},  // R7
        '{1'b0, 1'b1, 1'b1, 8'hB2, 4'd7},  // R7
        '{1'b1, 1'b0, 1'b0, 8'h85, 4'd2},  // R2 index write on E fall
        '{1'b1, 1'b1, 1'b0, 8'h05, 4'd3},  // R3 bit7 forced zero
        '{1'b1, 1'b0, 1'b0, 8'h20, 4'd2},
        '{1'b1, 1'b0, 1'b1, 8'h10, 4'd2},
        '{1'b1, 1'b0, 1'b0, 8'h22, 4'd2},
        '{1'b1, 1'b1, 1'b1, 8'h00, 4'd7},  // R7 dummy in 6800 style
        '{1'b1, 1'b1, 1'b1, 8'hA1, 4'd2}   // R2 read in 6800 style
    };

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic m68, input logic rs, input logic [7:0] v);
        @(negedge clk);
        mode_6800 = m68;
        bus_rs = rs; bus_din = v; bus_rnw = 1'b0;
        if (m68) bus_en = 1'b1; else bus_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_en = 1'b0; bus_wr_n = 1'b1;
        repeat (8) @(negedge clk);
        bus_rnw = 1'b1;
    endtask

    task automatic host_read(input logic m68, input logic rs, output logic [7:0] got);
        @(negedge clk);
        mode_6800 = m68;
        bus_rs = rs; bus_rnw = 1'b1;
        if (m68) bus_en = 1'b1; else bus_rd_n = 1'b0;
        repeat (5) @(negedge clk);
        got = bus_dout;
        bus_en = 1'b0; bus_rd_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int c0, w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_dout, 8'h00, "R9 dout after reset");
        chk({ctrl_we, ram_we, ram_re}, 3'b000, "R9 strobes after reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                host_read(VEC[i].m68, VEC[i].rs, r);
                chk(r, VEC[i].val, $sformatf("R%0d vector %0d", VEC[i].req, i));
            end else begin
                host_write(VEC[i].m68, VEC[i].rs, VEC[i].val);
            end
        end
        chk(mem[8'h10], 8'hA1, "R6 memory word 0x10");
        chk(mem[8'h11], 8'hB2, "R6 memory word 0x11 (pointer step)");

        // R4: control register write in 6800 style
        host_write(1'b1, 1'b0, 8'h05);
        c0 = ctrl_cnt; w0 = ram_wr_cnt;
        host_write(1'b1, 1'b1, 8'h5A);
        chk(ctrl_cnt - c0, 1, "R4 single control strobe");
        chk(last_caddr, 8'h05, "R4 control address");
        chk(last_cdata, 8'h5A, "R4 control data");
        chk(ram_wr_cnt - w0, 0, "R4 no memory write");

        // R5: pointer load makes no write strobes
        host_write(1'b0, 1'b0, 8'h20);
        c0 = ctrl_cnt; w0 = ram_wr_cnt;
        host_write(1'b0, 1'b1, 8'h30);
        chk(ctrl_cnt - c0 + ram_wr_cnt - w0, 0, "R5 pointer load no strobes");

        // R8: back-to-back short writes
        host_write(1'b0, 1'b0, 8'h22);
        @(negedge clk);
        bus_rs = 1'b1; bus_rnw = 1'b0;
        for (int k = 0; k < 3; k++) begin
            bus_din = 8'hC1 + 8'(k);
            bus_wr_n = 1'b0;
            repeat (3) @(negedge clk);
            bus_wr_n = 1'b1;
            repeat (3) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        chk(mem[8'h30], 8'hC1, "R8 burst word 0");
        chk(mem[8'h31], 8'hC2, "R8 burst word 1");
        chk(mem[8'h32], 8'hC3, "R8 burst word 2");

        // R10: foreign-style strobes ignored
        @(negedge clk);
        mode_6800 = 1'b0; bus_rs = 1'b0; bus_din = 8'h77; bus_rnw = 1'b0; bus_en = 1'b1;
        repeat (4) @(negedge clk);
        bus_en = 1'b0; bus_rnw = 1'b1;
        repeat (8) @(negedge clk);
        host_read(1'b0, 1'b0, r);
        chk(r, 8'h22, "R10 enable ignored in 8080 style");
        @(negedge clk);
        mode_6800 = 1'b1; bus_rs = 1'b0; bus_din = 8'h66; bus_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (8) @(negedge clk);
        host_read(1'b1, 1'b0, r);
        chk(r, 8'h22, "R10 write strobe ignored in 6800 style");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule